// File: doc/BRIEF.md
# External Interrupt Input Sampler

This block turns a set of active-low external interrupt pins into request flags that an interrupt controller can poll. Each pin passes through a two-flop synchronizer. A free-running machine-cycle phase counter then inspects it once every twelve clocks, on a single strobe cycle. A per-pin trigger-type bit selects how the sampled value drives the flag:

- **Level mode:** the flag follows the sampled level.
- **Falling-edge mode:** the flag latches when one sample reads high and the next reads low.

The controller clears a flag with a per-pin acknowledge strobe when it vectors to that source. Software reaches the flags and the trigger-type bits through one small control word. In that word the type and flag bits of each pin sit side by side, so another block can decode them. Software can set or clear any flag directly.

Top module: `eint_sampler`

## Requirements
- R1: `sample_tick` is high for exactly one clock in every 12 clocks. Pins are evaluated only on the clock edge that ends a `sample_tick` cycle, so flags never change because of a pin at any other edge.
- R2: With the pin's type bit at 0 (level mode), each sample loads the flag with 1 if the synchronized pin is low and 0 if it is high.
- R3: With the type bit at 1 (falling-edge mode), a sample sets the flag only when the previous sample read high and the current one reads low. The flag then stays set after the pin returns high. A pin held low across samples does not set it again.
- R4: In level mode, a low pulse of 3 clocks that starts just after a sample and ends well before the next sample has no effect on the flag.
- R5: An `hw_ack` bit clears the matching flag on the next edge. In edge mode the flag stays clear while the pin stays low. In level mode a pin still low sets the flag again at the next sample.
- R6: `reg_rdata` bit 2i holds the type bit of pin i and bit 2i+1 holds its flag: bit 0 = type 0, bit 1 = flag 0, bit 2 = type 1, bit 3 = flag 1. A `reg_wr` cycle loads both kinds of bit from `reg_wdata`, and flag values written are visible on the next clock.
- R7: When a sample sets a flag in the same cycle as a software write of 0 and an `hw_ack` to that flag, the flag ends up set. This holds in both edge and level mode.
- R8: After reset, all flags and type bits are 0 (level mode) and `reg_rdata` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_int_n | input | N_PINS | Asynchronous active-low interrupt pins |
| hw_ack | input | N_PINS | Per-pin clear strobe from the interrupt controller |
| reg_wr | input | 1 | Software write strobe for the control word |
| reg_wdata | input | 2*N_PINS | Control word write data: type at 2i, flag at 2i+1 |
| reg_rdata | output | 2*N_PINS | Control word read data, same layout |
| irq_flag | output | N_PINS | Request flags toward the interrupt controller |
| sample_tick | output | 1 | Machine-cycle sampling strobe |

## Verification
A corrupted phase counter shows at the ports as a `sample_tick` spacing other than twelve clocks, visible within two machine cycles. A stale previous-sample register shows as an edge flag that appears with no high-to-low history, or that reappears after an acknowledge while the pin is held low, by the next strobe. A wrong update priority shows one clock after a collision: a flag lost when a sample coincides with a clear. A wrong field position shows on the first read of the control word after a write.

// File: rtl/eint_pkg.sv
// Shared types for the external interrupt sampler.
// Assumes the control word layout of two bits per pin: type at 2i, flag at 2i+1.
package eint_pkg;

    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_mode_e;

    // Bit position of the trigger-type bit of pin i inside the control word.
    function automatic int type_pos(input int i);
        return 2 * i;
    endfunction

    // Bit position of the request flag of pin i inside the control word.
    function automatic int flag_pos(input int i);
        return 2 * i + 1;
    endfunction

endpackage

// File: rtl/eint_phase_gen.sv
// Machine-cycle phase counter. Counts CYCLE_LEN clocks and raises tick_o
// for one clock at SAMPLE_PHASE. Assumes SAMPLE_PHASE < CYCLE_LEN.
module eint_phase_gen #(
    parameter int CYCLE_LEN    = 12,
    parameter int SAMPLE_PHASE = 9
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = $clog2(CYCLE_LEN);

    logic [CNT_W-1:0] phase_q;

    // Advance the phase, wrapping at the end of a machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            phase_q <= '0;
        else if (phase_q == CNT_W'(CYCLE_LEN - 1))
            phase_q <= '0;
        else
            phase_q <= phase_q + 1'b1;
    end

    // Strobe on the fixed sampling phase.
    assign tick_o = (phase_q == CNT_W'(SAMPLE_PHASE));

endmodule

// File: rtl/eint_sync.sv
// Multi-flop synchronizer for asynchronous active-low pins.
// Resets to all ones (inactive), so no request appears out of reset.
module eint_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] chain_q [STAGES];

    // First stage captures the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q[0] <= '1;
        else        chain_q[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        // Each further stage re-registers the previous one.
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q[s] <= '1;
            else        chain_q[s] <= chain_q[s-1];
        end
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/eint_channel.sv
// One interrupt input: previous-sample register and request flag.
// Assumes pin_n_s is already synchronized and tick marks the sample cycle.
// Update order: sample result, then hardware clear, then software write.
module eint_channel
    import eint_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       pin_n_s,
    input  trig_mode_e mode,
    input  logic       hw_clr,
    input  logic       sw_wr,
    input  logic       sw_flag,
    output logic       flag
);
    logic prev_high_q;
    logic flag_q;
    logic fell;

    // A falling transition between two consecutive samples.
    assign fell = prev_high_q & ~pin_n_s;

    // Remember the level seen at the last sample.
    always_ff @(posedge clk) begin
        if (!rst_n)    prev_high_q <= 1'b1;
        else if (tick) prev_high_q <= pin_n_s;
    end

    // Flag update with the sampled set taking precedence over clears.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_q <= 1'b0;
        else if (tick && mode == TRIG_LEVEL)
            flag_q <= ~pin_n_s;
        else if (tick && fell)
            flag_q <= 1'b1;
        else if (hw_clr)
            flag_q <= 1'b0;
        else if (sw_wr)
            flag_q <= sw_flag;
    end

    assign flag = flag_q;

endmodule

// File: rtl/eint_sampler.sv
// External interrupt input sampler top. Synchronizes the pins, samples them
// once per machine cycle and keeps one flag and one trigger-type bit per pin,
// exposed through a control word (type at 2i, flag at 2i+1).
module eint_sampler
    import eint_pkg::*;
#(
    parameter int N_PINS       = 2,
    parameter int CYCLE_LEN    = 12,
    parameter int SAMPLE_PHASE = 9,
    parameter int SYNC_STAGES  = 2,
    localparam int REG_W       = 2 * N_PINS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_PINS-1:0] ext_int_n,
    input  logic [N_PINS-1:0] hw_ack,
    input  logic              reg_wr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic [N_PINS-1:0] irq_flag,
    output logic              sample_tick
);
    logic [N_PINS-1:0] pin_sync;
    logic [N_PINS-1:0] mode_q;

    eint_phase_gen #(
        .CYCLE_LEN   (CYCLE_LEN),
        .SAMPLE_PHASE(SAMPLE_PHASE)
    ) u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .tick_o(sample_tick)
    );

    eint_sync #(
        .WIDTH (N_PINS),
        .STAGES(SYNC_STAGES)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_int_n),
        .dout (pin_sync)
    );

    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
        // Trigger-type bit written by software.
        always_ff @(posedge clk) begin
            if (!rst_n)      mode_q[i] <= 1'b0;
            else if (reg_wr) mode_q[i] <= reg_wdata[type_pos(i)];
        end

        eint_channel u_chan (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (sample_tick),
            .pin_n_s(pin_sync[i]),
            .mode   (trig_mode_e'(mode_q[i])),
            .hw_clr (hw_ack[i]),
            .sw_wr  (reg_wr),
            .sw_flag(reg_wdata[flag_pos(i)]),
            .flag   (irq_flag[i])
        );

        assign reg_rdata[type_pos(i)] = mode_q[i];
        assign reg_rdata[flag_pos(i)] = irq_flag[i];
    end

endmodule

// File: rtl/eint_sampler_chk.sv
// Assertion checker for eint_sampler, attached by bind below.
// Assumes pin_s is the synchronized pin vector inside the top.
module eint_sampler_chk #(
    parameter int N_PINS    = 2,
    parameter int CYCLE_LEN = 12
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  sample_tick,
    input logic [N_PINS-1:0]     hw_ack,
    input logic                  reg_wr,
    input logic [2*N_PINS-1:0]   reg_wdata,
    input logic [2*N_PINS-1:0]   reg_rdata,
    input logic [N_PINS-1:0]     irq_flag,
    input logic [N_PINS-1:0]     pin_s
);
    localparam int GAP_W = $clog2(CYCLE_LEN) + 1;

    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    // Clocks elapsed since the last strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (sample_tick) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + 1'b1;
        end
    end

    // R1: strobes are exactly one machine cycle apart.
    p_tick_period_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_tick && seen_q) |-> gap_q == GAP_W'(CYCLE_LEN - 1));

    // R1: no strobe, no clear, no write means no flag change.
    p_flag_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && hw_ack == '0 && !reg_wr) |=> $stable(irq_flag));

    for (genvar i = 0; i < N_PINS; i++) begin : g_chk
        // R2: level mode flag equals the inverted sampled pin.
        p_level_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (sample_tick && !reg_rdata[2*i]) |=> irq_flag[i] == !$past(pin_s[i]));

        // R5: acknowledge away from a strobe clears the flag.
        p_ack_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (hw_ack[i] && !sample_tick) |=> !irq_flag[i]);

        // R6: software flag write lands on the next clock.
        p_sw_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && !sample_tick && !hw_ack[i]) |=> reg_rdata[2*i+1] == $past(reg_wdata[2*i+1]));

        // R6: type bit write lands on the next clock.
        p_type_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
            reg_wr |=> reg_rdata[2*i] == $past(reg_wdata[2*i]));
    end

endmodule

bind eint_sampler eint_sampler_chk #(
    .N_PINS   (N_PINS),
    .CYCLE_LEN(CYCLE_LEN)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sample_tick(sample_tick),
    .hw_ack     (hw_ack),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq_flag   (irq_flag),
    .pin_s      (pin_sync)
);

// File: tb/tb_eint_sampler.sv
// Scoreboard bench for eint_sampler: driver tasks push expected control-word
// values, a monitor pops and compares them at the following falling edge.
module tb_eint_sampler;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] ext_int_n = 2'b11;
    logic [1:0] hw_ack = 2'b00;
    logic       reg_wr = 1'b0;
    logic [3:0] reg_wdata = 4'h0;
    logic [3:0] reg_rdata;
    logic [1:0] irq_flag;
    logic       sample_tick;

    int applied = 0;
    int miscompares = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] rdata;
        string      tag;
    } exp_t;

    exp_t sb [$];

    always #5 clk = ~clk;

    eint_sampler dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_int_n  (ext_int_n),
        .hw_ack     (hw_ack),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .irq_flag   (irq_flag),
        .sample_tick(sample_tick)
    );

    // Monitor: compare every queued expectation at the next falling edge.
    initial begin
        forever begin
            @(negedge clk);
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                applied++;
                if (reg_rdata !== e.rdata || irq_flag !== {e.rdata[3], e.rdata[1]}) begin
                    miscompares++;
                    $display("FAIL %s: rdata=%b flags=%b expected rdata=%b flags=%b",
                             e.tag, reg_rdata, irq_flag, e.rdata, {e.rdata[3], e.rdata[1]});
                end
            end
        end
    end

    task automatic expect_word(input logic [3:0] v, input string tag);
        exp_t e;
        e.rdata = v;
        e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic check_int(input string tag, input int got, input int exp);
        applied++;
        if (got != exp) begin
            miscompares++;
            $display("FAIL %s: got %0d expected %0d", tag, got, exp);
        end
    endtask

    // Stop at the falling edge just before a sampling edge.
    task automatic wait_tick();
        do @(negedge clk); while (!sample_tick);
    endtask

    // Return just after a sample has been taken.
    task automatic after_sample();
        wait_tick();
        @(negedge clk);
        #1;
    endtask

    task automatic set_pins(input logic [1:0] v);
        @(negedge clk);
        ext_int_n = v;
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic reg_write(input logic [3:0] v);
        @(negedge clk);
        reg_wr = 1'b1;
        reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
        #1;
    endtask

    task automatic ack(input int i);
        @(negedge clk);
        hw_ack[i] = 1'b1;
        @(negedge clk);
        hw_ack = 2'b00;
        #1;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        expect_word(4'b0000, "R8 reset state");

        // R1: strobe spacing.
        for (int k = 0; k < 2; k++) begin
            int n;
            n = 0;
            wait_tick();
            do begin
                @(negedge clk);
                n++;
            end while (!sample_tick);
            check_int("R1 tick spacing", n, 12);
        end

        // R2: level mode follows the samples.
        after_sample();
        set_pins(2'b10);
        after_sample();
        expect_word(4'b0010, "R2 pin0 low sets flag0");
        set_pins(2'b01);
        after_sample();
        expect_word(4'b1000, "R2 pin0 high clears, pin1 low sets");
        set_pins(2'b11);
        after_sample();
        expect_word(4'b0000, "R2 both high");

        // R4: short pulse between samples is not seen.
        @(negedge clk);
        ext_int_n = 2'b10;
        repeat (3) @(negedge clk);
        ext_int_n = 2'b11;
        after_sample();
        expect_word(4'b0000, "R4 short pulse ignored");

        // R6: select falling-edge mode on both pins.
        reg_write(4'b0101);
        expect_word(4'b0101, "R6 type bits at 0 and 2");

        // R3: falling edge latches.
        after_sample();
        set_pins(2'b10);
        after_sample();
        expect_word(4'b0111, "R3 fall sets flag0");
        set_pins(2'b11);
        after_sample();
        expect_word(4'b0111, "R3 flag held after rise");
        ack(0);
        expect_word(4'b0101, "R5 ack clears edge flag");

        // R5: held-low pin does not re-set after acknowledge.
        after_sample();
        set_pins(2'b10);
        after_sample();
        expect_word(4'b0111, "R3 second fall sets flag0");
        ack(0);
        expect_word(4'b0101, "R5 ack clears with pin low");
        after_sample();
        expect_word(4'b0101, "R3 held low gives no new set");
        set_pins(2'b11);
        after_sample();
        expect_word(4'b0101, "R3 rise gives no set");

        // R7: edge set beats same-cycle clears.
        set_pins(2'b01);
        wait_tick();
        reg_wr = 1'b1;
        reg_wdata = 4'b0101;
        hw_ack = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0;
        hw_ack = 2'b00;
        #1;
        expect_word(4'b1101, "R7 edge set over clears");

        // R6: write back to level mode with flags cleared.
        after_sample();
        reg_write(4'b0000);
        expect_word(4'b0000, "R6 write clears flag1");

        // R7: level set beats same-cycle clears.
        wait_tick();
        reg_wr = 1'b1;
        reg_wdata = 4'b0000;
        hw_ack = 2'b10;
        @(negedge clk);
        reg_wr = 1'b0;
        hw_ack = 2'b00;
        #1;
        expect_word(4'b1000, "R7 level set over clears");

        // R5: level mode re-sets after acknowledge while pin low.
        ack(1);
        expect_word(4'b0000, "R5 ack clears level flag");
        after_sample();
        expect_word(4'b1000, "R5 level re-set on next sample");

        // R6: software set of flags in edge mode, pins idle.
        set_pins(2'b11);
        after_sample();
        reg_write(4'b1111);
        expect_word(4'b1111, "R6 software set visible next clock");
        reg_write(4'b0101);
        expect_word(4'b0101, "R6 software clear");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

endmodule